// File: doc/BRIEF.md
# Staged Clock Divider Bank

A bank of programmable divider lanes that all run from one source clock. Each lane produces a one-cycle enable pulse once every divide-factor source cycles, where the divide factor is the lane's ratio value plus one. The rest of the chip uses these pulses as clock enables, so the whole design stays on a single clock.

Software writes new ratios into staging registers through a plain synchronous register port. Staged values do not touch the running lanes. A write to the command register starts a GO sequence of four source cycles. When it completes, every lane whose change flag or align-enable bit is set takes its staged ratio and restarts its count on the same cycle, so those lanes pulse together. Lanes with neither bit set keep their ratio and their phase.

Register map (6-bit address, 16-bit data): 0x00 command (bit 0 = start GO), 0x01 status (bit 0 = GO in progress), 0x02 align-enable mask (bit n = lane n), 0x03 change flags (bit n = lane n, read only), 0x10+n staged ratio of lane n, 0x20+n active ratio of lane n (read only). Addresses that are not mapped read as 0.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, status, change flags, align mask and all staged and active ratios read 0, and every lane's enable is high on every cycle (divide by 1).
- R2: A lane with active ratio r pulses its enable for one cycle once every r+1 source cycles.
- R3: Writing a staged ratio while idle updates the readback at 0x10+n but leaves the active ratio at 0x20+n and the lane's pulse train unchanged until a GO completes.
- R4: A staged ratio write whose value differs from the lane's active ratio sets that lane's change flag; a write equal to the active ratio leaves the flag as it was; flags never clear except at GO completion.
- R5: Writing 1 to bit 0 of the command register while idle makes status bit 0 read 1 for exactly four cycles, starting the cycle after the write.
- R6: At GO completion every lane whose change flag or align bit is set loads its staged ratio and restarts, so all such lanes pulse in the first cycle in which status reads 0 again.
- R7: A lane with neither change flag nor align bit set keeps its active ratio and its pulse phase across a GO.
- R8: All change flags read 0 once a GO has completed.
- R9: A GO start written while status reads 1 is ignored: the running GO still ends four cycles after it began.
- R10: Writes to staged ratios or the align mask while status reads 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock for all lanes and registers |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 6 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| div_en | output | 16 | One enable pulse train per lane |

## Verification
The embedded properties watch on every cycle that a lane counter never passes its ratio, that a lane with a nonzero ratio never pulses on two adjacent cycles, that the active ratio moves only on a GO apply, that flags only drop at completion, that GO status lasts four cycles, and that the selected lanes pulse together right after apply. What they cannot show is the end-to-end effect seen through the register port: the measured periods for chosen ratios, the exact cycle status falls as read by software, the phase of an untouched lane across a GO, and the readback of registers after writes that should have been dropped; these come from the bench's scenarios.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants for the staged clock divider bank.
// Holds the register map and the fixed GO sequence length.
package clkdiv_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 6;
    localparam int GO_CYCLES = 4;
    localparam int GO_CNT_W  = $clog2(GO_CYCLES);

    localparam logic [ADDR_W-1:0] ADDR_CMD    = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_STAT   = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_ALIGN  = 6'h02;
    localparam logic [ADDR_W-1:0] ADDR_FLAG   = 6'h03;
    localparam logic [1:0]        PAGE_STAGE  = 2'b01;
    localparam logic [1:0]        PAGE_ACTIVE = 2'b10;

    typedef enum logic { GO_IDLE = 1'b0, GO_RUN = 1'b1 } go_state_t;
endpackage

// File: rtl/clkdiv_go_seq.sv
// Module: GO sequencer. Runs a fixed-length GO window when a start request
// arrives while idle and flags the last cycle of the window as the apply cycle.
// Assumes: start requests during a running window are dropped.
module clkdiv_go_seq
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    output logic busy,
    output logic apply
);
    go_state_t             state;
    logic [GO_CNT_W-1:0]   gcnt;
    localparam logic [GO_CNT_W-1:0] LAST = GO_CNT_W'(GO_CYCLES - 1);

    // Purpose: step the GO window counter and return to idle after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GO_IDLE;
            gcnt  <= '0;
        end else if (state == GO_IDLE) begin
            if (go_req) begin
                state <= GO_RUN;
                gcnt  <= '0;
            end
        end else if (gcnt == LAST) begin
            state <= GO_IDLE;
            gcnt  <= '0;
        end else begin
            gcnt <= gcnt + 1'b1;
        end
    end

    // Purpose: expose status and the single apply cycle.
    always_comb begin
        busy  = (state == GO_RUN);
        apply = busy && (gcnt == LAST);
    end

    // R5: the window lasts exactly four cycles.
    a_r5_go_stays: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ##3 busy);
    a_r5_go_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ##4 !busy);
    // R9: a start request mid-window does not extend or restart it.
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !apply && go_req) |=> (busy && gcnt != '0));
endmodule

// File: rtl/clkdiv_lane.sv
// Module: one divider lane. Counts 0..ratio and pulses en when the count is 0.
// On a restart it loads the staged ratio and resets the count, so the next
// cycle carries a pulse. Assumes restart is a single-cycle strobe.
module clkdiv_lane #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [RATIO_W-1:0] staged,
    output logic [RATIO_W-1:0] active,
    output logic               en
);
    logic [RATIO_W-1:0] cnt;

    // Purpose: hold the active ratio, replaced only on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= '0;
        else if (restart) active <= staged;
    end

    // Purpose: free-running phase counter that wraps at the active ratio.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart)        cnt <= '0;
        else if (cnt == active)  cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // Purpose: pulse at phase zero.
    assign en = (cnt == '0);

    // R2: counter stays within the divide window.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= active);
    // R2: a lane with nonzero ratio never pulses on two adjacent cycles.
    a_r2_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        (en && active != '0 && !restart) |=> !en);
    // R3: the active ratio only moves on a restart.
    a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(active));
endmodule

// File: rtl/clkdiv_regs.sv
// Module: register file. Holds staged ratios, the align mask and change
// flags, decodes the GO start, and serves reads. Assumes writes are single-
// cycle strobes; staging and mask writes during GO are dropped.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_OUT = 16,
    parameter int RATIO_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       busy,
    input  logic                       apply,
    input  logic [NUM_OUT*RATIO_W-1:0] active_flat,
    output logic [NUM_OUT*RATIO_W-1:0] staged_flat,
    output logic [NUM_OUT-1:0]         sel,
    output logic                       go_req,
    output logic [DATA_W-1:0]          rdata
);
    logic [RATIO_W-1:0] staged [NUM_OUT];
    logic [RATIO_W-1:0] active [NUM_OUT];
    logic [NUM_OUT-1:0] align;
    logic [NUM_OUT-1:0] flags;
    logic [NUM_OUT-1:0] stage_hit;
    logic               wr_idle;
    logic [3:0]         idx;

    assign wr_idle = wr && !busy;
    assign idx     = addr[3:0];
    assign go_req  = wr && (addr == ADDR_CMD) && wdata[0];

    genvar g;
    generate
        for (g = 0; g < NUM_OUT; g++) begin : g_lane_io
            // Purpose: unpack active ratios and pack staged ratios per lane.
            assign active[g] = active_flat[g*RATIO_W +: RATIO_W];
            assign staged_flat[g*RATIO_W +: RATIO_W] = staged[g];
            assign stage_hit[g] = wr_idle && (addr[5:4] == PAGE_STAGE) && (idx == 4'(g));
        end
    endgenerate

    // Purpose: capture staged ratios written while idle.
    always_ff @(posedge clk) begin
        for (int n = 0; n < NUM_OUT; n++) begin
            if (!rst_n)            staged[n] <= '0;
            else if (stage_hit[n]) staged[n] <= wdata[RATIO_W-1:0];
        end
    end

    // Purpose: set a lane's change flag on a differing write, clear all on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else if (apply) flags <= '0;
        else begin
            for (int n = 0; n < NUM_OUT; n++) begin
                if (stage_hit[n] && (wdata[RATIO_W-1:0] != active[n])) flags[n] <= 1'b1;
            end
        end
    end

    // Purpose: hold the align mask written while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) align <= '0;
        else if (wr_idle && addr == ADDR_ALIGN) align <= wdata[NUM_OUT-1:0];
    end

    // Purpose: lanes that restart at the end of GO.
    assign sel = align | flags;

    // Purpose: read multiplexer over the register map.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_STAT) rdata[0] = busy;
        else if (addr == ADDR_ALIGN) rdata[NUM_OUT-1:0] = align;
        else if (addr == ADDR_FLAG)  rdata[NUM_OUT-1:0] = flags;
        else if (int'(idx) < NUM_OUT) begin
            if (addr[5:4] == PAGE_STAGE)       rdata[RATIO_W-1:0] = staged[idx];
            else if (addr[5:4] == PAGE_ACTIVE) rdata[RATIO_W-1:0] = active[idx];
        end
    end

    // R4: flags are sticky until a GO applies.
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ((flags & $past(flags)) == $past(flags)));
    // R8: flags are empty after apply.
    a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (flags == '0));
    // R10: mask writes during GO are dropped.
    a_r10_align_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && addr == ADDR_ALIGN) |=> $stable(align));
endmodule

// File: rtl/clkdiv_bank.sv
// Module: top of the staged clock divider bank. Connects the register file,
// the GO sequencer and one divider lane per output.
// Assumes NUM_OUT <= 16 and RATIO_W <= 16.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NUM_OUT = 16,
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_OUT-1:0] div_en
);
    logic [NUM_OUT*RATIO_W-1:0] active_flat;
    logic [NUM_OUT*RATIO_W-1:0] staged_flat;
    logic [NUM_OUT-1:0]         sel;
    logic                       go_req;
    logic                       busy;
    logic                       apply;

    clkdiv_regs #(.NUM_OUT(NUM_OUT), .RATIO_W(RATIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .apply(apply), .active_flat(active_flat),
        .staged_flat(staged_flat), .sel(sel), .go_req(go_req), .rdata(reg_rdata)
    );

    clkdiv_go_seq u_go (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .busy(busy), .apply(apply)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_OUT; g++) begin : g_lane
            clkdiv_lane #(.RATIO_W(RATIO_W)) u_lane (
                .clk(clk), .rst_n(rst_n),
                .restart(apply && sel[g]),
                .staged(staged_flat[g*RATIO_W +: RATIO_W]),
                .active(active_flat[g*RATIO_W +: RATIO_W]),
                .en(div_en[g])
            );
        end
    endgenerate

    // R6: every selected lane pulses in the cycle after apply.
    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> ((div_en & $past(sel)) == $past(sel)));
endmodule

// File: tb/clkdiv_bank_test.sv
`timescale 1ns/1ps
module clkdiv_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] div_en;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    clkdiv_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_en(div_en)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Table walked after reset, one cycle per entry (R1, R3, R4, R6 setup).
    localparam vec_t VECS [14] = '{
        '{1'b0, 6'h01, 16'h0000, 16'h0000, 8'd1},
        '{1'b0, 6'h03, 16'h0000, 16'h0000, 8'd1},
        '{1'b0, 6'h02, 16'h0000, 16'h0000, 8'd1},
        '{1'b0, 6'h15, 16'h0000, 16'h0000, 8'd1},
        '{1'b1, 6'h10, 16'h0003, 16'h0000, 8'd3},
        '{1'b0, 6'h10, 16'h0000, 16'h0003, 8'd3},
        '{1'b0, 6'h20, 16'h0000, 16'h0000, 8'd3},
        '{1'b0, 6'h03, 16'h0000, 16'h0001, 8'd4},
        '{1'b1, 6'h11, 16'h0000, 16'h0000, 8'd4},
        '{1'b0, 6'h03, 16'h0000, 16'h0001, 8'd4},
        '{1'b1, 6'h12, 16'h0005, 16'h0000, 8'd4},
        '{1'b0, 6'h03, 16'h0000, 16'h0005, 8'd4},
        '{1'b1, 6'h02, 16'h0008, 16'h0000, 8'd6},
        '{1'b0, 6'h02, 16'h0000, 16'h0008, 8'd6}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a write now (at a negedge), release at the next negedge.
    task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic meas_period(input int lane, output int per);
        per = 0;
        for (int k = 0; k < 40 && !div_en[lane]; k++) @(negedge clk);
        @(negedge clk);
        per = 1;
        for (int k = 0; k < 40 && !div_en[lane]; k++) begin
            @(negedge clk);
            per++;
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int per;
        int last;
        int bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all lanes pulse every cycle after reset.
        for (int k = 0; k < 3; k++) begin
            check(div_en == 16'hFFFF, "R1", div_en, 16'hFFFF);
            @(negedge clk);
        end

        for (int i = 0; i < 14; i++) begin
            if (VECS[i].wr) begin
                wr_reg(VECS[i].addr, VECS[i].data);
            end else begin
                rd_reg(VECS[i].addr, v);
                tests++;
                if (v !== VECS[i].exp) begin
                    fails++;
                    $display("FAIL R%0d addr=%h actual=%0d expected=%0d",
                             VECS[i].req, VECS[i].addr, v, VECS[i].exp);
                end
                @(negedge clk);
            end
        end

        // R3: staged ratios have not reached lanes 0 and 2.
        for (int k = 0; k < 3; k++) begin
            check(div_en[0] && div_en[2], "R3", {div_en[2], div_en[0]}, 3);
            @(negedge clk);
        end

        // First GO: lanes 0, 2 flagged, lane 3 aligned.
        wr_reg(6'h00, 16'h0001);
        for (int k = 1; k <= 4; k++) begin
            rd_reg(6'h01, v);
            check(v == 16'h0001, "R5", v, 1);
            @(negedge clk);
        end
        rd_reg(6'h01, v);
        check(v == 16'h0000, "R5", v, 0);
        check((div_en & 16'h000D) == 16'h000D, "R6", div_en & 16'h000D, 16'h000D);
        rd_reg(6'h20, v);
        check(v == 16'h0003, "R6", v, 3);
        rd_reg(6'h03, v);
        check(v == 16'h0000, "R8", v, 0);

        // R2: measured periods.
        meas_period(0, per);
        check(per == 4, "R2", per, 4);
        meas_period(2, per);
        check(per == 6, "R2", per, 6);
        meas_period(1, per);
        check(per == 1, "R2", per, 1);

        // Lane 5 to ratio 2 via GO.
        @(negedge clk);
        wr_reg(6'h15, 16'h0002);
        wr_reg(6'h00, 16'h0001);
        repeat (5) @(negedge clk);
        rd_reg(6'h25, v);
        check(v == 16'h0002, "R6", v, 2);

        // R7: lane 5 keeps phase while lane 0 is changed by another GO.
        wr_reg(6'h10, 16'h0001);
        last = -1;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (div_en[5]) begin
                if (last >= 0 && (i - last) != 3) bad++;
                last = i;
            end
            if (i == 5) begin
                reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 16'h0001;
            end else begin
                reg_wr = 1'b0;
            end
        end
        check(bad == 0 && last >= 0, "R7", bad, 0);
        rd_reg(6'h20, v);
        check(v == 16'h0001, "R6", v, 1);
        rd_reg(6'h03, v);
        check(v == 16'h0000, "R8", v, 0);

        // R9 and R10: writes during a running GO.
        @(negedge clk);
        wr_reg(6'h00, 16'h0001);
        wr_reg(6'h00, 16'h0001);
        wr_reg(6'h02, 16'hFFFF);
        rd_reg(6'h01, v);
        check(v == 16'h0001, "R5", v, 1);
        @(negedge clk);
        rd_reg(6'h01, v);
        check(v == 16'h0001, "R9", v, 1);
        @(negedge clk);
        rd_reg(6'h01, v);
        check(v == 16'h0000, "R9", v, 0);
        rd_reg(6'h02, v);
        check(v == 16'h0008, "R10", v, 8);

        // R10: staged ratio write during GO is dropped.
        @(negedge clk);
        wr_reg(6'h00, 16'h0001);
        wr_reg(6'h14, 16'h0007);
        repeat (4) @(negedge clk);
        rd_reg(6'h14, v);
        check(v == 16'h0000, "R10", v, 0);
        rd_reg(6'h03, v);
        check(v == 16'h0000, "R10", v, 0);

        finish_run();
    end
endmodule